// File: doc/BRIEF.md
# Message Receive Matching Engine

This block sits on the receive side of a message-passing network interface. Two request streams come in. Incoming message envelopes carry a sender rank, a tag and a length. Receive requests posted by the host carry a wanted rank, a wanted tag, a capacity, and two wildcard flags. A receive with a wildcard flag accepts any rank, any tag, or both. The engine pairs each message with a posted receive. The only match keys are rank and tag. It then reports a completion with the real sender, the real tag and the delivered length.

Unmatched messages are stored in the unexpected table, with one of two treatments:

- **Eager.** A message no longer than the eager limit counts as already holding its payload. It needs one of a fixed set of preallocated buffer slots.
- **Rendezvous.** A longer message keeps only its envelope. When a matching receive appears, the engine pulses a clear-to-send toward the sender alongside the completion.

Receives that find no waiting message are stored in the posted table. Both tables keep arrival order, and a search always picks the oldest eligible entry. The engine makes at most one match decision per cycle.

Top module: `msg_match_engine`

## Requirements
- R1: A message and a receive match when the message rank equals the receive rank (or the receive wildcards the rank) and the message tag equals the receive tag.
- R2: A receive with its any-tag flag set matches every tag, subject only to the rank rule.
- R3: A message of length at most EAGER_MAX (64) that finds no posted receive is held in the unexpected table. When a matching receive arrives later, it completes with done_eager=1 and no clear-to-send.
- R4: At most EAGER_SLOTS (2) eager messages are held at once. If every slot is taken and no posted receive matches, env_ready is low for an eager envelope. A rendezvous envelope is still accepted while the unexpected table has room.
- R5: A message longer than EAGER_MAX completes with done_eager=0 and a cts_valid pulse carrying its rank and tag. This happens whether the receive came first or the envelope did.
- R6: done_len is the message length when it fits the receive capacity, with done_overflow=0. Otherwise done_len equals the capacity and done_overflow=1.
- R7: A completion reports the message's own rank and tag, also for wildcard receives.
- R8: Searches take the oldest matching entry, in both the posted table and the unexpected table.
- R9: env_valid has priority, and rcv_ready is low while it is high. rcv_ready is also low when the posted table is full and no stored message matches. env_ready is also low when the unexpected table is full and no posted receive matches.
- R10: done_valid (and cts_valid when due) is a one-cycle pulse in the cycle after the accepting handshake. After reset, both are low and both readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| env_valid | input | 1 | Envelope offered |
| env_ready | output | 1 | Envelope accepted this cycle |
| env_src | input | 4 | Sender rank |
| env_tag | input | 6 | Message tag |
| env_len | input | 10 | Message length |
| rcv_valid | input | 1 | Receive request offered |
| rcv_ready | output | 1 | Receive request accepted this cycle |
| rcv_src | input | 4 | Wanted sender rank |
| rcv_tag | input | 6 | Wanted tag |
| rcv_any_src | input | 1 | Rank wildcard |
| rcv_any_tag | input | 1 | Tag wildcard |
| rcv_cap | input | 10 | Receive capacity |
| done_valid | output | 1 | Completion pulse |
| done_src | output | 4 | Actual sender rank |
| done_tag | output | 6 | Actual tag |
| done_len | output | 10 | Delivered length |
| done_overflow | output | 1 | Message exceeded capacity |
| done_eager | output | 1 | Completion came from the eager path |
| cts_valid | output | 1 | Clear-to-send pulse to a rendezvous sender |
| cts_src | output | 4 | Rank of the sender being cleared |
| cts_tag | output | 6 | Tag being cleared |

## Verification
The assertions take the inputs to be plain per-cycle offers. An offer that is not accepted may be dropped or changed in the next cycle, because the engine holds no state for it. The assertions also take reset to start the run. The slot bound and the single-operation rule then rest only on the tables' own contents. The stimulus drives both streams at random every cycle, including simultaneous offers and frequent wildcards. It uses small rank and tag ranges so that matches, full tables and exhausted slots all occur often.

// File: rtl/msg_match_pkg.sv
package msg_match_pkg;
  localparam int SRC_W = 4;
  localparam int TAG_W = 6;
  localparam int LEN_W = 10;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [TAG_W-1:0] tag;
    logic [LEN_W-1:0] len;
    logic             eager;
  } unexp_t;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [TAG_W-1:0] tag;
    logic [LEN_W-1:0] cap;
    logic             any_src;
    logic             any_tag;
  } posted_t;

  // rank/tag key compare with optional wildcards on the receive side
  function automatic logic key_hit(input logic any_s, input logic any_t,
                                   input logic [SRC_W-1:0] want_s,
                                   input logic [TAG_W-1:0] want_t,
                                   input logic [SRC_W-1:0] have_s,
                                   input logic [TAG_W-1:0] have_t);
    return (any_s || (want_s == have_s)) && (any_t || (want_t == have_t));
  endfunction

  function automatic logic [LEN_W-1:0] fit_len(input logic [LEN_W-1:0] len,
                                               input logic [LEN_W-1:0] cap);
    return (len > cap) ? cap : len;
  endfunction

  function automatic logic too_long(input logic [LEN_W-1:0] len,
                                    input logic [LEN_W-1:0] cap);
    return len > cap;
  endfunction
endpackage

// File: rtl/mm_first_hit.sv
module mm_first_hit #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mm_order_queue.sv
module mm_order_queue #(
  parameter int DEPTH = 4,
  parameter int W = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push_en,
  input  logic [W-1:0]              push_data,
  input  logic                      pop_en,
  input  logic [IW-1:0]             pop_idx,
  output logic [DEPTH-1:0][W-1:0]   ent,
  output logic [DEPTH-1:0]          vld,
  output logic                      full
);
  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [DEPTH-1:0]        vld_q;
  logic [DEPTH-1:0][W-1:0] mem_up;
  logic [DEPTH-1:0]        vld_up;
  logic [DEPTH-1:0]        prev_ok;

  // entry i+1 as seen from entry i, used when an entry below is removed
  assign mem_up  = {{W{1'b0}}, mem_q[DEPTH-1:1]};
  assign vld_up  = {1'b0, vld_q[DEPTH-1:1]};
  assign prev_ok = {vld_q[DEPTH-2:0], 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
      vld_q <= '0;
    end else if (pop_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i >= int'(pop_idx)) begin
          mem_q[i] <= mem_up[i];
          vld_q[i] <= vld_up[i];
        end
      end
    end else if (push_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!vld_q[i] && prev_ok[i]) begin
          mem_q[i] <= push_data;
          vld_q[i] <= 1'b1;
        end
      end
    end
  end

  assign ent  = mem_q;
  assign vld  = vld_q;
  assign full = vld_q[DEPTH-1];
endmodule

// File: rtl/msg_match_engine.sv
module msg_match_engine
  import msg_match_pkg::*;
#(
  parameter int UQ_DEPTH    = 4,
  parameter int PQ_DEPTH    = 4,
  parameter int EAGER_SLOTS = 2,
  parameter int EAGER_MAX   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             env_valid,
  output logic             env_ready,
  input  logic [SRC_W-1:0] env_src,
  input  logic [TAG_W-1:0] env_tag,
  input  logic [LEN_W-1:0] env_len,
  input  logic             rcv_valid,
  output logic             rcv_ready,
  input  logic [SRC_W-1:0] rcv_src,
  input  logic [TAG_W-1:0] rcv_tag,
  input  logic             rcv_any_src,
  input  logic             rcv_any_tag,
  input  logic [LEN_W-1:0] rcv_cap,
  output logic             done_valid,
  output logic [SRC_W-1:0] done_src,
  output logic [TAG_W-1:0] done_tag,
  output logic [LEN_W-1:0] done_len,
  output logic             done_overflow,
  output logic             done_eager,
  output logic             cts_valid,
  output logic [SRC_W-1:0] cts_src,
  output logic [TAG_W-1:0] cts_tag
);
  localparam int UW    = $bits(unexp_t);
  localparam int PW    = $bits(posted_t);
  localparam int UQ_IW = (UQ_DEPTH > 1) ? $clog2(UQ_DEPTH) : 1;
  localparam int PQ_IW = (PQ_DEPTH > 1) ? $clog2(PQ_DEPTH) : 1;
  localparam int CNT_W = $clog2(UQ_DEPTH + 1);

  // table storage
  logic [UQ_DEPTH-1:0][UW-1:0] uq_raw;
  logic [PQ_DEPTH-1:0][PW-1:0] pq_raw;
  logic [UQ_DEPTH-1:0]         uq_vld;
  logic [PQ_DEPTH-1:0]         pq_vld;
  logic                        uq_full, pq_full;
  unexp_t                      uq_ent [UQ_DEPTH];
  posted_t                     pq_ent [PQ_DEPTH];

  // search results
  logic [UQ_DEPTH-1:0] uq_hit_vec;
  logic [PQ_DEPTH-1:0] pq_hit_vec;
  logic [UQ_DEPTH-1:0] uq_eager_bits;
  logic                uq_found, pq_found;
  logic [UQ_IW-1:0]    uq_idx;
  logic [PQ_IW-1:0]    pq_idx;
  unexp_t              uq_sel;
  posted_t             pq_sel;

  // named events for the checker
  logic             env_is_eager;
  logic [CNT_W-1:0] eager_cnt;
  logic             slot_free;
  logic             env_fire, rcv_fire;
  logic             ev_env_match, ev_env_store, ev_rcv_match, ev_rcv_post;

  always_comb begin
    for (int i = 0; i < UQ_DEPTH; i++) begin
      uq_ent[i]        = unexp_t'(uq_raw[i]);
      uq_eager_bits[i] = uq_vld[i] && uq_ent[i].eager;
      uq_hit_vec[i]    = uq_vld[i] &&
        key_hit(rcv_any_src, rcv_any_tag, rcv_src, rcv_tag, uq_ent[i].src, uq_ent[i].tag);
    end
    for (int i = 0; i < PQ_DEPTH; i++) begin
      pq_ent[i]     = posted_t'(pq_raw[i]);
      pq_hit_vec[i] = pq_vld[i] &&
        key_hit(pq_ent[i].any_src, pq_ent[i].any_tag, pq_ent[i].src, pq_ent[i].tag,
                env_src, env_tag);
    end
  end

  mm_first_hit #(.N(UQ_DEPTH)) u_uq_pick (.req(uq_hit_vec), .found(uq_found), .idx(uq_idx));
  mm_first_hit #(.N(PQ_DEPTH)) u_pq_pick (.req(pq_hit_vec), .found(pq_found), .idx(pq_idx));

  assign uq_sel = uq_ent[uq_idx];
  assign pq_sel = pq_ent[pq_idx];

  assign env_is_eager = env_len <= LEN_W'(EAGER_MAX);
  assign eager_cnt    = CNT_W'($countones(uq_eager_bits));
  assign slot_free    = eager_cnt < CNT_W'(EAGER_SLOTS);

  assign env_ready = pq_found || (!uq_full && (!env_is_eager || slot_free));
  assign rcv_ready = !env_valid && (uq_found || !pq_full);
  assign env_fire  = env_valid && env_ready;
  assign rcv_fire  = rcv_valid && rcv_ready;

  assign ev_env_match = env_fire && pq_found;
  assign ev_env_store = env_fire && !pq_found;
  assign ev_rcv_match = rcv_fire && uq_found;
  assign ev_rcv_post  = rcv_fire && !uq_found;

  unexp_t  uq_new;
  posted_t pq_new;
  assign uq_new = '{src: env_src, tag: env_tag, len: env_len, eager: env_is_eager};
  assign pq_new = '{src: rcv_src, tag: rcv_tag, cap: rcv_cap,
                    any_src: rcv_any_src, any_tag: rcv_any_tag};

  mm_order_queue #(.DEPTH(UQ_DEPTH), .W(UW)) u_unexp (
    .clk(clk), .rst_n(rst_n),
    .push_en(ev_env_store), .push_data(UW'(uq_new)),
    .pop_en(ev_rcv_match), .pop_idx(uq_idx),
    .ent(uq_raw), .vld(uq_vld), .full(uq_full)
  );

  mm_order_queue #(.DEPTH(PQ_DEPTH), .W(PW)) u_posted (
    .clk(clk), .rst_n(rst_n),
    .push_en(ev_rcv_post), .push_data(PW'(pq_new)),
    .pop_en(ev_env_match), .pop_idx(pq_idx),
    .ent(pq_raw), .vld(pq_vld), .full(pq_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid    <= 1'b0;
      done_src      <= '0;
      done_tag      <= '0;
      done_len      <= '0;
      done_overflow <= 1'b0;
      done_eager    <= 1'b0;
      cts_valid     <= 1'b0;
      cts_src       <= '0;
      cts_tag       <= '0;
    end else begin
      done_valid <= ev_env_match || ev_rcv_match;
      cts_valid  <= 1'b0;
      if (ev_env_match) begin
        done_src      <= env_src;
        done_tag      <= env_tag;
        done_len      <= fit_len(env_len, pq_sel.cap);
        done_overflow <= too_long(env_len, pq_sel.cap);
        done_eager    <= env_is_eager;
        cts_valid     <= !env_is_eager;
        cts_src       <= env_src;
        cts_tag       <= env_tag;
      end else if (ev_rcv_match) begin
        done_src      <= uq_sel.src;
        done_tag      <= uq_sel.tag;
        done_len      <= fit_len(uq_sel.len, rcv_cap);
        done_overflow <= too_long(uq_sel.len, rcv_cap);
        done_eager    <= uq_sel.eager;
        cts_valid     <= !uq_sel.eager;
        cts_src       <= uq_sel.src;
        cts_tag       <= uq_sel.tag;
      end
    end
  end
endmodule

// File: rtl/msg_match_engine_sva.sv
module msg_match_engine_sva #(
  parameter int EAGER_SLOTS = 2,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             env_valid,
  input logic             rcv_ready,
  input logic             env_fire,
  input logic             rcv_fire,
  input logic [CNT_W-1:0] eager_cnt,
  input logic             done_valid,
  input logic             done_eager,
  input logic             cts_valid
);
  assert_single_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(env_fire && rcv_fire));

  assert_rcv_yields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    env_valid |-> !rcv_ready);

  assert_slot_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(eager_cnt) <= EAGER_SLOTS);

  assert_cts_rndv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cts_valid |-> (done_valid && !done_eager));

  assert_eager_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_eager) |-> !cts_valid);

  assert_done_after_fire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(env_fire || rcv_fire));
endmodule

bind msg_match_engine msg_match_engine_sva #(.EAGER_SLOTS(EAGER_SLOTS), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .env_valid(env_valid), .rcv_ready(rcv_ready),
  .env_fire(env_fire), .rcv_fire(rcv_fire), .eager_cnt(eager_cnt),
  .done_valid(done_valid), .done_eager(done_eager), .cts_valid(cts_valid)
);

// File: tb/msg_match_engine_tb.sv
module msg_match_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int UQD = 4, PQD = 4, SLOTS = 2, EMAX = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic env_valid = 0, rcv_valid = 0, rcv_any_src = 0, rcv_any_tag = 0;
  logic [3:0] env_src = 0, rcv_src = 0;
  logic [5:0] env_tag = 0, rcv_tag = 0;
  logic [9:0] env_len = 0, rcv_cap = 0;
  logic env_ready, rcv_ready, done_valid, done_overflow, done_eager, cts_valid;
  logic [3:0] done_src, cts_src;
  logic [5:0] done_tag, cts_tag;
  logic [9:0] done_len;

  msg_match_engine u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference tables, oldest first
  int u_src[$], u_tag[$], u_len[$]; bit u_eg[$];
  int p_src[$], p_tag[$], p_cap[$]; bit p_as[$], p_at[$];
  bit x_done = 0, x_ovf = 0, x_eg = 0, x_cts = 0;
  int x_src = 0, x_tag = 0, x_len = 0;

  function automatic bit wants(bit as, bit at, int ws, int wt, int hs, int ht);
    return (as || ws == hs) && (at || wt == ht);
  endfunction

  function automatic int held_eager();
    int n = 0;
    foreach (u_eg[i]) if (u_eg[i]) n++;
    return n;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step(bit ev, int es, int et, int el,
                      bit rv, int rs, int rt, bit ras, bit rat, int rc);
    int ph, uh;
    bit er, rr;
    @(negedge clk);
    chk("R10 done_valid", done_valid, x_done);
    chk("R5 cts_valid", cts_valid, x_cts);
    if (x_done) begin
      chk("R1 R7 done_src", done_src, x_src);
      chk("R2 R7 done_tag", done_tag, x_tag);
      chk("R6 R8 done_len", done_len, x_len);
      chk("R6 done_overflow", done_overflow, x_ovf);
      chk("R3 R5 done_eager", done_eager, x_eg);
    end
    if (x_cts) begin
      chk("R5 cts_src", cts_src, x_src);
      chk("R5 cts_tag", cts_tag, x_tag);
    end
    env_valid = ev; env_src = 4'(es); env_tag = 6'(et); env_len = 10'(el);
    rcv_valid = rv; rcv_src = 4'(rs); rcv_tag = 6'(rt);
    rcv_any_src = ras; rcv_any_tag = rat; rcv_cap = 10'(rc);
    #1;
    ph = -1;
    for (int i = 0; i < p_src.size(); i++)
      if (ph < 0 && wants(p_as[i], p_at[i], p_src[i], p_tag[i], es, et)) ph = i;
    uh = -1;
    for (int i = 0; i < u_src.size(); i++)
      if (uh < 0 && wants(ras, rat, rs, rt, u_src[i], u_tag[i])) uh = i;
    er = (ph >= 0) || (u_src.size() < UQD && (el > EMAX || held_eager() < SLOTS));
    rr = !ev && (uh >= 0 || p_src.size() < PQD);
    chk("R4 R9 env_ready", env_ready, er);
    chk("R9 rcv_ready", rcv_ready, rr);
    x_done = 0; x_cts = 0;
    if (ev && er) begin
      if (ph >= 0) begin
        x_done = 1; x_src = es; x_tag = et; x_eg = (el <= EMAX); x_cts = !x_eg;
        x_len = (el > p_cap[ph]) ? p_cap[ph] : el; x_ovf = (el > p_cap[ph]);
        p_src.delete(ph); p_tag.delete(ph); p_cap.delete(ph); p_as.delete(ph); p_at.delete(ph);
      end else begin
        u_src.push_back(es); u_tag.push_back(et); u_len.push_back(el); u_eg.push_back(el <= EMAX);
      end
    end else if (rv && rr) begin
      if (uh >= 0) begin
        x_done = 1; x_src = u_src[uh]; x_tag = u_tag[uh]; x_eg = u_eg[uh]; x_cts = !x_eg;
        x_len = (u_len[uh] > rc) ? rc : u_len[uh]; x_ovf = (u_len[uh] > rc);
        u_src.delete(uh); u_tag.delete(uh); u_len.delete(uh); u_eg.delete(uh);
      end else begin
        p_src.push_back(rs); p_tag.push_back(rt); p_cap.push_back(rc);
        p_as.push_back(ras); p_at.push_back(rat);
      end
    end
  endtask

  task automatic env_only(int s, int t, int l);
    step(1, s, t, l, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rcv_only(int s, int t, bit as, bit at, int c);
    step(0, 0, 0, 0, 1, s, t, as, at, c);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R10 reset env_ready", env_ready, 1);
    chk("R10 reset rcv_ready", rcv_ready, 1);
    chk("R10 reset done_valid", done_valid, 0);
    chk("R10 reset cts_valid", cts_valid, 0);
    // R3: eager message waits, receive completes it without clear-to-send
    env_only(1, 2, 10);
    rcv_only(1, 2, 0, 0, 20);
    // R5 and R7: stored rendezvous envelope met by a rank-wildcard receive
    env_only(2, 3, 200);
    rcv_only(0, 3, 1, 0, 300);
    // R5: receive first, rendezvous envelope completes at once
    rcv_only(3, 4, 0, 0, 100);
    env_only(3, 4, 90);
    // R6: message too long for the capacity
    rcv_only(1, 1, 0, 0, 8);
    env_only(1, 1, 20);
    // R4: slots exhausted, third eager refused, rendezvous still taken
    env_only(5, 1, 30);
    env_only(6, 1, 31);
    env_only(7, 1, 32);
    env_only(7, 1, 100);
    repeat (3) rcv_only(0, 0, 1, 1, 500);
    // R8: oldest unexpected message wins
    env_only(4, 5, 11);
    env_only(4, 5, 12);
    rcv_only(4, 5, 0, 0, 50);
    rcv_only(4, 5, 0, 0, 50);
    // R8: oldest posted receive wins
    rcv_only(0, 6, 1, 0, 50);
    rcv_only(9, 6, 0, 0, 40);
    env_only(9, 6, 45);
    env_only(9, 6, 30);
    // R9: simultaneous offers, envelope goes first
    step(1, 10, 7, 5, 1, 10, 7, 0, 0, 9);
    rcv_only(10, 7, 0, 0, 9);
    // R2: tag wildcard
    rcv_only(8, 0, 0, 1, 60);
    env_only(8, 33, 40);
    // R9: fill posted table, then a non-matching receive is refused
    repeat (5) rcv_only(12, 9, 0, 0, 10);
    repeat (4) env_only(12, 9, 5);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(1, 160),
           $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(1, 160));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule